// File: doc/BRIEF.md
# Display DMA Descriptor Fetch Unit

This block refreshes the per-channel descriptor state of a multi-channel display DMA once per frame. On a frame-start pulse it walks the channels in ascending index order. For each enabled channel it picks a fetch pointer: either a pending software branch target or the next-descriptor address stored from the previous frame. It checks that the whole 16-byte descriptor lies inside one of two permitted memory windows. It then reads four 32-bit words over a simple request/response memory port and stores them as the channel's next-descriptor address, source address, frame ID and command.

After each enabled channel is handled, the loaded source address is validated. A zero source, or one outside both windows, raises a one-cycle bus-error event for that channel. A branch that has its interrupt enable bit set raises a one-cycle branch-status event. Software writes a channel's descriptor address and branch register through a small write port. Any channel's state, including a decoded view of its command word, can be read through a combinational read port. A one-cycle done pulse marks the end of the walk.

Top module: `dma_desc_fetch`

## Requirements
- R1: After reset every channel's next-descriptor, source, frame ID, command and branch registers read zero, and `mem_req`, `busy`, `done`, `bs_pulse` and `ber_pulse` are low.
- R2: A configuration write with `cfg_sel`=0 stores `cfg_wdata` with bits 3:0 forced to zero as the channel's next-descriptor address. A write with `cfg_sel`=1 stores `cfg_wdata` AND 0xFFFFFFF3 as the channel's branch register.
- R3: A `frame_start` accepted while idle clears the stored source address of every channel, enabled or not, before any fetch.
- R4: Channels are visited in ascending index order, and only channels whose `ch_enable` bit is 1 are fetched. A disabled channel's registers other than the source stay unchanged.
- R5: A fetch reads four words at P, P+4, P+8 and P+12, where P is the fetch pointer with bits 3:0 cleared. The reads are issued one at a time, with no new request while one is outstanding. Words 0 to 3 are stored as next-descriptor, source, frame ID and command.
- R6: If branch bit 0 (request) is set when a channel is visited, the fetch pointer is branch bits 31:4 with bits 3:0 zero, and bit 0 is then cleared with the other bits kept. `bs_pulse[ch]` pulses for one cycle only if branch bit 1 (interrupt enable) is also set.
- R7: A branch is taken once. On the following frame the channel fetches from the next-descriptor address loaded by the branch fetch.
- R8: A descriptor is fetched only if, for some window with base B and size S, P >= B and P+16 <= B+S. Otherwise the channel issues no request.
- R9: After each enabled channel is handled, `ber_pulse[ch]` pulses for one cycle if its source is zero or lies in neither window. A source is inside a window when it is >= B and <= B+S, so the end address counts as inside. A channel skipped by R8 therefore also flags a bus error.
- R10: For the channel selected by `rd_ch`, `rd_len` shows command bits 20:2 with bits 1:0 zero, `rd_eof_en` shows bit 21, `rd_sof_en` shows bit 22 and `rd_pal` shows bit 26.
- R11: `busy` is high from the cycle after an accepted `frame_start` until the walk ends. `done` pulses for exactly one cycle after the last channel is handled. A `frame_start` that arrives while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Start a descriptor walk (taken while idle) |
| ch_enable | input | NUM_CH | Per-channel participation enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0: next-descriptor address, 1: branch register |
| cfg_ch | input | CHW | Channel addressed by the write |
| cfg_wdata | input | 32 | Write data |
| rd_ch | input | CHW | Channel shown on the read port |
| rd_next | output | 32 | Stored next-descriptor address |
| rd_src | output | 32 | Stored source address |
| rd_fid | output | 32 | Stored frame ID |
| rd_cmd | output | 32 | Stored command word |
| rd_branch | output | 32 | Branch register |
| rd_len | output | 21 | Command length field (bits 20:2) |
| rd_eof_en | output | 1 | Command end-of-frame interrupt enable |
| rd_sof_en | output | 1 | Command start-of-frame interrupt enable |
| rd_pal | output | 1 | Command palette-load flag |
| mem_req | output | 1 | Memory read request (one cycle) |
| mem_addr | output | 32 | Memory read word address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| bs_pulse | output | NUM_CH | One-cycle branch-status event per channel |
| ber_pulse | output | NUM_CH | One-cycle bus-error event per channel |

## Verification
The bench keeps all seven channels but shrinks the windows to one at 0x1000 of size 0x1008 and one at 0x8000 of size 0x100. The odd 0x1008 size lets an aligned descriptor start inside window 0 yet run past its end, so the descriptor span check can be reached with legal 16-byte-aligned pointers. The small windows also put the inclusive source end (0x8100 against 0x8101) and the below-base case within a few descriptors. A two-cycle memory latency keeps the single-outstanding rule and the word ordering visible.

// File: rtl/dfu_pkg.sv
package dfu_pkg;
   localparam int unsigned WORD_W      = 32;
   localparam int unsigned DESC_WORDS  = 4;
   localparam int unsigned DESC_BYTES  = 16;

   localparam int unsigned BR_REQ_BIT  = 0;
   localparam int unsigned BR_INT_BIT  = 1;
   localparam logic [31:0] BRANCH_WMASK = 32'hFFFF_FFF3;
   localparam logic [31:0] ALIGN16_MASK = 32'hFFFF_FFF0;

   localparam int unsigned CMD_EOF_BIT = 21;
   localparam int unsigned CMD_SOF_BIT = 22;
   localparam int unsigned CMD_PAL_BIT = 26;
   localparam logic [31:0] CMD_LEN_MASK = 32'h001F_FFFC;

   localparam logic CFG_SEL_DESC   = 1'b0;
   localparam logic CFG_SEL_BRANCH = 1'b1;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PICK,
      ST_REQ,
      ST_WAIT,
      ST_CHECK,
      ST_DONE
   } fetch_state_t;
endpackage

// File: rtl/dfu_win_check.sv
module dfu_win_check #(
   parameter int unsigned SPAN    = 16,
   parameter logic [31:0] W0_BASE = 32'h0,
   parameter logic [31:0] W0_SIZE = 32'h0,
   parameter logic [31:0] W1_BASE = 32'h0,
   parameter logic [31:0] W1_SIZE = 32'h0
) (
   input  logic [31:0] addr,
   output logic        ok
);
   localparam logic [32:0] W0_END = {1'b0, W0_BASE} + {1'b0, W0_SIZE};
   localparam logic [32:0] W1_END = {1'b0, W1_BASE} + {1'b0, W1_SIZE};

   if ((SPAN % 4) != 0) begin : g_bad_span
      $error("dfu_win_check: SPAN must be a multiple of 4");
   end

   logic [32:0] addr_w;
   assign addr_w = {1'b0, addr};

   if (SPAN == 0) begin : g_point
      // single address, end of window counts as inside
      assign ok = ((addr >= W0_BASE) && (addr_w <= W0_END)) ||
                  ((addr >= W1_BASE) && (addr_w <= W1_END));
   end else begin : g_span
      logic [32:0] last_w;
      assign last_w = addr_w + 33'(SPAN);
      assign ok = ((addr >= W0_BASE) && (last_w <= W0_END)) ||
                  ((addr >= W1_BASE) && (last_w <= W1_END));
   end
endmodule

// File: rtl/dfu_chan_regs.sv
module dfu_chan_regs
   import dfu_pkg::*;
#(
   parameter int unsigned NUM_CH = 7,
   parameter int unsigned CHW    = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cfg_we,
   input  logic                         cfg_sel,
   input  logic [CHW-1:0]               cfg_ch,
   input  logic [31:0]                  cfg_wdata,
   input  logic                         clr_src,
   input  logic                         brq_clr,
   input  logic [CHW-1:0]               brq_ch,
   input  logic                         ld_we,
   input  logic [CHW-1:0]               ld_ch,
   input  logic [1:0]                   ld_idx,
   input  logic [31:0]                  ld_data,
   output logic [NUM_CH-1:0][31:0]      next_q,
   output logic [NUM_CH-1:0][31:0]      src_q,
   output logic [NUM_CH-1:0][31:0]      fid_q,
   output logic [NUM_CH-1:0][31:0]      cmd_q,
   output logic [NUM_CH-1:0][31:0]      br_q
);
   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      logic [31:0] nx_r, sr_r, fi_r, cm_r, br_r;
      logic        sel_cfg, sel_brq, sel_ld;

      assign sel_cfg = cfg_we  && (cfg_ch == CHW'(g));
      assign sel_brq = brq_clr && (brq_ch == CHW'(g));
      assign sel_ld  = ld_we   && (ld_ch  == CHW'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            nx_r <= '0;
            sr_r <= '0;
            fi_r <= '0;
            cm_r <= '0;
            br_r <= '0;
         end else begin
            if (sel_cfg) begin
               if (cfg_sel == CFG_SEL_DESC) nx_r <= cfg_wdata & ALIGN16_MASK;
               else                         br_r <= cfg_wdata & BRANCH_WMASK;
            end
            // sequencer updates take precedence over a same-cycle write
            if (sel_brq) br_r[BR_REQ_BIT] <= 1'b0;
            if (clr_src) sr_r <= '0;
            if (sel_ld) begin
               case (ld_idx)
                  2'd0:    nx_r <= ld_data;
                  2'd1:    sr_r <= ld_data;
                  2'd2:    fi_r <= ld_data;
                  default: cm_r <= ld_data;
               endcase
            end
         end
      end

      assign next_q[g] = nx_r;
      assign src_q[g]  = sr_r;
      assign fid_q[g]  = fi_r;
      assign cmd_q[g]  = cm_r;
      assign br_q[g]   = br_r;
   end
endmodule

// File: rtl/dfu_fetch_ctrl.sv
module dfu_fetch_ctrl
   import dfu_pkg::*;
#(
   parameter int unsigned NUM_CH  = 7,
   parameter int unsigned CHW     = 3,
   parameter logic [31:0] W0_BASE = 32'h0,
   parameter logic [31:0] W0_SIZE = 32'h0,
   parameter logic [31:0] W1_BASE = 32'h0,
   parameter logic [31:0] W1_SIZE = 32'h0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     frame_start,
   input  logic [NUM_CH-1:0]        ch_en,
   input  logic [NUM_CH-1:0][31:0]  next_q,
   input  logic [NUM_CH-1:0][31:0]  src_q,
   input  logic [NUM_CH-1:0][31:0]  br_q,
   input  logic                     mem_rvalid,
   input  logic [31:0]              mem_rdata,
   output logic                     mem_req,
   output logic [31:0]              mem_addr,
   output logic                     clr_src,
   output logic                     brq_clr,
   output logic [CHW-1:0]           brq_ch,
   output logic                     ld_we,
   output logic [CHW-1:0]           ld_ch,
   output logic [1:0]               ld_idx,
   output logic [31:0]              ld_data,
   output logic                     busy,
   output logic                     done,
   output logic [NUM_CH-1:0]        bs_pulse,
   output logic [NUM_CH-1:0]        ber_pulse
);
   localparam logic [CHW-1:0] LAST_CH  = CHW'(NUM_CH - 1);
   localparam logic [1:0]     LAST_IDX = 2'(DESC_WORDS - 1);

   fetch_state_t      st_q;
   logic [CHW-1:0]    ch_q;
   logic [1:0]        idx_q;
   logic [31:0]       base_q;
   logic [NUM_CH-1:0] bs_q, ber_q;

   logic [31:0] br_w, nx_w, src_w, ptr_w;
   logic        use_br, desc_ok, src_ok, src_bad, last_ch, en_w;

   assign br_w    = br_q[ch_q];
   assign nx_w    = next_q[ch_q];
   assign src_w   = src_q[ch_q];
   assign en_w    = ch_en[ch_q];
   assign use_br  = br_w[BR_REQ_BIT];
   assign ptr_w   = (use_br ? br_w : nx_w) & ALIGN16_MASK;
   assign last_ch = (ch_q == LAST_CH);
   assign src_bad = (src_w == '0) || !src_ok;

   dfu_win_check #(
      .SPAN(DESC_BYTES), .W0_BASE(W0_BASE), .W0_SIZE(W0_SIZE),
      .W1_BASE(W1_BASE), .W1_SIZE(W1_SIZE)
   ) desc_win_i (
      .addr(ptr_w),
      .ok  (desc_ok)
   );

   dfu_win_check #(
      .SPAN(0), .W0_BASE(W0_BASE), .W0_SIZE(W0_SIZE),
      .W1_BASE(W1_BASE), .W1_SIZE(W1_SIZE)
   ) src_win_i (
      .addr(src_w),
      .ok  (src_ok)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         ch_q   <= '0;
         idx_q  <= '0;
         base_q <= '0;
         bs_q   <= '0;
         ber_q  <= '0;
      end else begin
         bs_q  <= '0;
         ber_q <= '0;
         case (st_q)
            ST_IDLE: begin
               if (frame_start) begin
                  ch_q <= '0;
                  st_q <= ST_PICK;
               end
            end
            ST_PICK: begin
               if (en_w) begin
                  if (use_br && br_w[BR_INT_BIT]) bs_q[ch_q] <= 1'b1;
                  if (desc_ok) begin
                     base_q <= ptr_w;
                     idx_q  <= '0;
                     st_q   <= ST_REQ;
                  end else begin
                     st_q <= ST_CHECK;
                  end
               end else if (last_ch) begin
                  st_q <= ST_DONE;
               end else begin
                  ch_q <= ch_q + 1'b1;
               end
            end
            ST_REQ: st_q <= ST_WAIT;
            ST_WAIT: begin
               if (mem_rvalid) begin
                  if (idx_q == LAST_IDX) begin
                     st_q <= ST_CHECK;
                  end else begin
                     idx_q <= idx_q + 1'b1;
                     st_q  <= ST_REQ;
                  end
               end
            end
            ST_CHECK: begin
               ber_q[ch_q] <= src_bad;
               if (last_ch) begin
                  st_q <= ST_DONE;
               end else begin
                  ch_q <= ch_q + 1'b1;
                  st_q <= ST_PICK;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign clr_src   = (st_q == ST_IDLE) && frame_start;
   assign brq_clr   = (st_q == ST_PICK) && en_w && use_br;
   assign brq_ch    = ch_q;
   assign ld_we     = (st_q == ST_WAIT) && mem_rvalid;
   assign ld_ch     = ch_q;
   assign ld_idx    = idx_q;
   assign ld_data   = mem_rdata;
   assign mem_req   = (st_q == ST_REQ);
   assign mem_addr  = {base_q[31:4], idx_q, 2'b00};
   assign busy      = (st_q != ST_IDLE);
   assign done      = (st_q == ST_DONE);
   assign bs_pulse  = bs_q;
   assign ber_pulse = ber_q;
endmodule

// File: rtl/dma_desc_fetch.sv
module dma_desc_fetch
   import dfu_pkg::*;
#(
   parameter int unsigned NUM_CH  = 7,
   parameter logic [31:0] W0_BASE = 32'hA000_0000,
   parameter logic [31:0] W0_SIZE = 32'h0400_0000,
   parameter logic [31:0] W1_BASE = 32'h5C00_0000,
   parameter logic [31:0] W1_SIZE = 32'h0004_0000,
   localparam int unsigned CHW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frame_start,
   input  logic [NUM_CH-1:0]  ch_enable,
   input  logic               cfg_we,
   input  logic               cfg_sel,
   input  logic [CHW-1:0]     cfg_ch,
   input  logic [31:0]        cfg_wdata,
   input  logic [CHW-1:0]     rd_ch,
   output logic [31:0]        rd_next,
   output logic [31:0]        rd_src,
   output logic [31:0]        rd_fid,
   output logic [31:0]        rd_cmd,
   output logic [31:0]        rd_branch,
   output logic [20:0]        rd_len,
   output logic               rd_eof_en,
   output logic               rd_sof_en,
   output logic               rd_pal,
   output logic               mem_req,
   output logic [31:0]        mem_addr,
   input  logic               mem_rvalid,
   input  logic [31:0]        mem_rdata,
   output logic               busy,
   output logic               done,
   output logic [NUM_CH-1:0]  bs_pulse,
   output logic [NUM_CH-1:0]  ber_pulse
);
   if (NUM_CH < 1 || NUM_CH > 32) begin : g_bad_nch
      $error("dma_desc_fetch: NUM_CH must lie in 1..32");
   end
   if (W0_SIZE < DESC_BYTES || W1_SIZE < DESC_BYTES) begin : g_bad_win
      $error("dma_desc_fetch: each window must hold one descriptor");
   end

   logic [NUM_CH-1:0][31:0] next_q, src_q, fid_q, cmd_q, br_q;
   logic                    clr_src, brq_clr, ld_we;
   logic [CHW-1:0]          brq_ch, ld_ch;
   logic [1:0]              ld_idx;
   logic [31:0]             ld_data;

   dfu_chan_regs #(.NUM_CH(NUM_CH), .CHW(CHW)) regs_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_sel  (cfg_sel),
      .cfg_ch   (cfg_ch),
      .cfg_wdata(cfg_wdata),
      .clr_src  (clr_src),
      .brq_clr  (brq_clr),
      .brq_ch   (brq_ch),
      .ld_we    (ld_we),
      .ld_ch    (ld_ch),
      .ld_idx   (ld_idx),
      .ld_data  (ld_data),
      .next_q   (next_q),
      .src_q    (src_q),
      .fid_q    (fid_q),
      .cmd_q    (cmd_q),
      .br_q     (br_q)
   );

   dfu_fetch_ctrl #(
      .NUM_CH(NUM_CH), .CHW(CHW),
      .W0_BASE(W0_BASE), .W0_SIZE(W0_SIZE),
      .W1_BASE(W1_BASE), .W1_SIZE(W1_SIZE)
   ) ctrl_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_start(frame_start),
      .ch_en      (ch_enable),
      .next_q     (next_q),
      .src_q      (src_q),
      .br_q       (br_q),
      .mem_rvalid (mem_rvalid),
      .mem_rdata  (mem_rdata),
      .mem_req    (mem_req),
      .mem_addr   (mem_addr),
      .clr_src    (clr_src),
      .brq_clr    (brq_clr),
      .brq_ch     (brq_ch),
      .ld_we      (ld_we),
      .ld_ch      (ld_ch),
      .ld_idx     (ld_idx),
      .ld_data    (ld_data),
      .busy       (busy),
      .done       (done),
      .bs_pulse   (bs_pulse),
      .ber_pulse  (ber_pulse)
   );

   logic        rd_ok;
   logic [31:0] cmd_w;

   assign rd_ok     = (32'(rd_ch) < NUM_CH);
   assign rd_next   = rd_ok ? next_q[rd_ch] : '0;
   assign rd_src    = rd_ok ? src_q[rd_ch]  : '0;
   assign rd_fid    = rd_ok ? fid_q[rd_ch]  : '0;
   assign cmd_w     = rd_ok ? cmd_q[rd_ch]  : '0;
   assign rd_branch = rd_ok ? br_q[rd_ch]   : '0;
   assign rd_cmd    = cmd_w;
   assign rd_len    = 21'(cmd_w & CMD_LEN_MASK);
   assign rd_eof_en = cmd_w[CMD_EOF_BIT];
   assign rd_sof_en = cmd_w[CMD_SOF_BIT];
   assign rd_pal    = cmd_w[CMD_PAL_BIT];
endmodule

// File: rtl/dfu_fetch_chk.sv
module dfu_fetch_chk #(
   parameter int unsigned NUM_CH = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_req,
   input logic [31:0]       mem_addr,
   input logic              mem_rvalid,
   input logic              busy,
   input logic              done,
   input logic [NUM_CH-1:0] bs_pulse,
   input logic [NUM_CH-1:0] ber_pulse
);
   logic [1:0] outst_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                         outst_q <= '0;
      else if (mem_req && !mem_rvalid)    outst_q <= outst_q + 2'd1;
      else if (!mem_req && mem_rvalid)    outst_q <= outst_q - 2'd1;
   end

   AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (outst_q == 2'd0)); // R5
   AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[1:0] == 2'b00)); // R5
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R11
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req); // R11
   AST_BS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bs_pulse)); // R6
   AST_BER_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ber_pulse)); // R9
   AST_BER_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n)
      (|ber_pulse) |-> busy); // R9
endmodule

bind dma_desc_fetch dfu_fetch_chk #(.NUM_CH(NUM_CH)) chk_i (.*);

// File: tb/dma_desc_fetch_tb_top.sv
`timescale 1ns/1ps
module dma_desc_fetch_tb_top;
   localparam int NCH = 7;
   localparam int CW  = 3;
   localparam int LAT = 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            frame_start = 1'b0;
   logic [NCH-1:0]  ch_enable = '0;
   logic            cfg_we = 1'b0;
   logic            cfg_sel = 1'b0;
   logic [CW-1:0]   cfg_ch = '0;
   logic [31:0]     cfg_wdata = '0;
   logic [CW-1:0]   rd_ch = '0;
   logic [31:0]     rd_next, rd_src, rd_fid, rd_cmd, rd_branch;
   logic [20:0]     rd_len;
   logic            rd_eof_en, rd_sof_en, rd_pal;
   logic            mem_req;
   logic [31:0]     mem_addr;
   logic            mem_rvalid = 1'b0;
   logic [31:0]     mem_rdata = '0;
   logic            busy, done;
   logic [NCH-1:0]  bs_pulse, ber_pulse;

   always #5 clk = ~clk;

   dma_desc_fetch #(
      .NUM_CH(NCH),
      .W0_BASE(32'h0000_1000), .W0_SIZE(32'h0000_1008),
      .W1_BASE(32'h0000_8000), .W1_SIZE(32'h0000_0100)
   ) dut_i (.*);

   // memory model and monitor
   logic [31:0] mem [int unsigned];
   int unsigned req_q [$];
   int          done_cnt = 0;
   logic [NCH-1:0] bs_seen = '0, ber_seen = '0;
   logic [31:0] pend_a = '0;
   int          lat_cnt = 0;

   function automatic logic [31:0] mem_rd(input logic [31:0] a);
      return mem.exists(a) ? mem[a] : 32'h0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         mem_rvalid <= 1'b0;
         lat_cnt    <= 0;
      end else begin
         mem_rvalid <= 1'b0;
         if (mem_req) begin
            pend_a  <= mem_addr;
            lat_cnt <= LAT;
            req_q.push_back(mem_addr);
         end else if (lat_cnt != 0) begin
            lat_cnt <= lat_cnt - 1;
            if (lat_cnt == 1) begin
               mem_rvalid <= 1'b1;
               mem_rdata  <= mem_rd(pend_a);
            end
         end
         if (done) done_cnt <= done_cnt + 1;
         bs_seen  <= bs_seen | bs_pulse;
         ber_seen <= ber_seen | ber_pulse;
      end
   end

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic put_desc(input int unsigned a, input logic [31:0] w0, w1, w2, w3);
      mem[a] = w0; mem[a+4] = w1; mem[a+8] = w2; mem[a+12] = w3;
   endtask

   task automatic cfg_write(input logic sel, input int ch, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_ch = CW'(ch); cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic run_frame(input string tag);
      int d0;
      d0 = done_cnt;
      req_q.delete();
      bs_seen = '0; ber_seen = '0;
      @(negedge clk); frame_start = 1'b1;
      @(negedge clk); frame_start = 1'b0;
      for (int i = 0; i < 2000 && done_cnt == d0; i++) @(negedge clk);
      @(negedge clk);
      chk({tag, " done seen (R11)"}, 32'(done_cnt - d0), 32'd1);
   endtask

   task automatic chk_reqs(input string tag, input int unsigned b0, input int unsigned b1, input int n);
      chk({tag, " req count"}, 32'(req_q.size()), 32'(n));
      if (req_q.size() == n) begin
         for (int i = 0; i < n; i++)
            chk({tag, " req addr"}, req_q[i], (i < 4) ? b0 + 4*i : b1 + 4*(i-4));
      end
   endtask

   task automatic t_reset;
      for (int c = 0; c < NCH; c++) begin
         rd_ch = CW'(c); #1;
         chk("R1 next", rd_next, 0); chk("R1 src", rd_src, 0);
         chk("R1 fid", rd_fid, 0); chk("R1 cmd", rd_cmd, 0);
         chk("R1 branch", rd_branch, 0);
      end
      chk("R1 outputs", {mem_req, busy, done, |bs_pulse, |ber_pulse}, 0);
   endtask

   task automatic t_cfg_masks;
      cfg_write(1'b0, 2, 32'h1234_567F);
      cfg_write(1'b1, 2, 32'hFFFF_FFFF);
      rd_ch = 2; #1;
      chk("R2 desc align", rd_next, 32'h1234_5670);
      chk("R2 branch mask", rd_branch, 32'hFFFF_FFF3);
      cfg_write(1'b1, 2, 32'h0);
   endtask

   task automatic t_basic;
      cfg_write(1'b0, 0, 32'h1100);
      ch_enable = 7'b000_0001;
      run_frame("basic");
      chk_reqs("R5 basic", 32'h1100, 0, 4);
      rd_ch = 0; #1;
      chk("R5 next", rd_next, 32'h1200); chk("R5 src", rd_src, 32'h1800);
      chk("R5 fid", rd_fid, 32'hABCD);   chk("R5 cmd", rd_cmd, 32'h0460_0104);
      chk("R10 len", 32'(rd_len), 32'h104);
      chk("R10 flags", {rd_eof_en, rd_sof_en, rd_pal}, 3'b111);
      chk("R9 no ber basic", 32'(ber_seen), 0);
   endtask

   task automatic t_order;
      cfg_write(1'b0, 1, 32'h1300);
      cfg_write(1'b0, 4, 32'h1400);
      ch_enable = 7'b001_0010;
      run_frame("order");
      chk_reqs("R4 order", 32'h1300, 32'h1400, 8);
      rd_ch = 0; #1;
      chk("R3 disabled src cleared", rd_src, 0);
      chk("R4 disabled next kept", rd_next, 32'h1200);
      rd_ch = 4; #1;
      chk("R5 ch4 fid", rd_fid, 32'h22);
      chk("R10 ch4 flags", {rd_eof_en, rd_sof_en, rd_pal}, 3'b100);
      chk("R10 ch4 len", 32'(rd_len), 32'h8);
   endtask

   task automatic t_branch;
      cfg_write(1'b1, 1, 32'h1503);
      ch_enable = 7'b000_0010;
      run_frame("br1");
      chk_reqs("R6 branch target", 32'h1500, 0, 4);
      chk("R6 bs pulse", 32'(bs_seen), 32'h02);
      rd_ch = 1; #1;
      chk("R6 req bit cleared", rd_branch, 32'h1502);
      chk("R9 src at window end ok", 32'(ber_seen), 0);
      run_frame("br2");
      chk_reqs("R7 chain resumes", 32'h1600, 0, 4);
      chk("R7 no bs", 32'(bs_seen), 0);
      chk("R9 src past end", 32'(ber_seen), 32'h02);
      cfg_write(1'b1, 1, 32'h1701);
      run_frame("br3");
      chk_reqs("R6 quiet branch", 32'h1700, 0, 4);
      chk("R6 no bs without enable", 32'(bs_seen), 0);
      rd_ch = 1; #1;
      chk("R6 quiet cleared", rd_branch, 32'h1700);
      chk("R9 w0 inclusive end", 32'(ber_seen), 0);
   endtask

   task automatic t_window;
      ch_enable = 7'b000_1000;
      cfg_write(1'b0, 3, 32'h2000);
      run_frame("win_end");
      chk_reqs("R8 straddles end", 0, 0, 0);
      chk("R9 skipped ber", 32'(ber_seen), 32'h08);
      cfg_write(1'b0, 3, 32'h0FF0);
      run_frame("win_low");
      chk_reqs("R8 below base", 0, 0, 0);
      cfg_write(1'b0, 3, 32'h1FF0);
      run_frame("win_fit");
      chk_reqs("R8 fits exactly", 32'h1FF0, 0, 4);
      chk("R9 zero source", 32'(ber_seen), 32'h08);
   endtask

   task automatic t_busy;
      int d0;
      cfg_write(1'b0, 0, 32'h1100);
      ch_enable = 7'b000_0001;
      d0 = done_cnt;
      req_q.delete();
      @(negedge clk); frame_start = 1'b1;
      @(negedge clk); frame_start = 1'b0;
      chk("R11 busy", 32'(busy), 1);
      repeat (3) @(negedge clk);
      frame_start = 1'b1;
      @(negedge clk); frame_start = 1'b0;
      repeat (60) @(negedge clk);
      chk("R11 single done", 32'(done_cnt - d0), 1);
      chk("R11 restart ignored", 32'(req_q.size()), 4);
      chk("R11 idle after", 32'(busy), 0);
   endtask

   initial begin
      put_desc(32'h1100, 32'h1200, 32'h1800, 32'hABCD, 32'h0460_0104);
      put_desc(32'h1300, 32'h1310, 32'h1900, 32'h11,   32'h0000_0010);
      put_desc(32'h1400, 32'h1410, 32'h1A00, 32'h22,   32'h0020_0008);
      put_desc(32'h1500, 32'h1600, 32'h8100, 32'h33,   32'h0040_0000);
      put_desc(32'h1600, 32'h1100, 32'h8101, 32'h44,   32'h0);
      put_desc(32'h1700, 32'h1100, 32'h2008, 32'h66,   32'h0);
      put_desc(32'h1FF0, 32'h1100, 32'h0,    32'h55,   32'h0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_cfg_masks();
      t_basic();
      t_order();
      t_branch();
      t_window();
      t_busy();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule